// File: doc/BRIEF.md
# Dual Edge-Qualified Counter Capture

This block keeps a free-running counter and two capture channels. Each channel watches one external trigger line. The line is sampled on selectable sampling ticks, and a level change is trusted only once two consecutive samples agree on the new level. A trusted change that matches the channel's programmed polarity copies the current counter value into that channel's capture register. The same change raises a one-cycle event output and sets a sticky flag.

Software sets up and reads the block through a plain parallel register port. There are four registers. The control register holds the run field, the two polarity fields and the two sampling-source bits. The flag register holds the capture and wrap flags, which are cleared by writing 1. The other two are the capture registers, and the live counter can also be read. The prescaled sampling tick comes from outside the block.

Each channel chooses its own sampling source. One choice samples on every system clock, which suits a line used as a count clock. The other samples only on cycles where the external tick is high, which suits a line used as a capture trigger.

Top module: `dual_edge_capture`

## Requirements
- R1: After synchronous reset, every readable register reads 0 and both event outputs are low.
- R2: While the 2-bit run field (control bits 1:0) is nonzero, the counter advances by exactly 1 each clock. While the field is 00, the counter holds its value.
- R3: When the counter steps from all-ones to zero, the wrap flag (flag register bit 2) is set.
- R4: A new trigger level is accepted only after two consecutive samples have seen it. A level that lasts for a single sample causes no capture.
- R5: The capture fires one system clock after the second confirming sample. It stores the counter value present at that clock, so two triggers k clocks apart give captures that differ by k.
- R6: Each channel's 2-bit polarity field selects which accepted changes capture: 00 falling, 01 rising, 10 none, 11 both. Channel 0 uses control bits 3:2 and channel 1 uses bits 5:4.
- R7: Each channel's source bit (control bit 6 for channel 0, bit 7 for channel 1) selects its sampling. A 1 samples on every clock. A 0 samples only on clocks where sample_tick is high.
- R8: Every capture gives a one-cycle pulse on cap_evt[ch] and sets flag bit ch. Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged.
- R9: When both channels qualify in the same clock, both capture registers receive the same value.
- R10: Reads return, one clock later, the register at the address given: 0 control, 1 flags, 2 capture 0, 3 capture 1, 4 counter. Addresses 5 to 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_tick | input | 1 | Prescaled sampling enable for channels set to tick sampling |
| trig | input | 2 | External trigger lines, one per channel |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | CNT_W | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | CNT_W | Registered read data |
| cap_evt | output | 2 | One-cycle capture pulse per channel |

## Verification
The assertions assume that the trigger lines and sample_tick are already synchronous to clk and change only between clock edges. The bench meets this by driving every input on the falling edge. The assertions also assume that sample_tick is a single-cycle enable and that software does not write the flag register while expecting a flag to be set. The stimulus produces tick pulses with a fixed period of four clocks. It holds each trigger level for a whole number of tick periods, and it clears flags only before or after a capture scenario, never during one.

// File: rtl/dec_pkg.sv
package dec_pkg;
  localparam int NCH    = 2;
  localparam int ADDR_W = 3;

  typedef enum logic [1:0] {
    EDGE_FALL = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_OFF  = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_sel_e;

  typedef struct packed {
    logic [1:0] src;
    edge_sel_e  sel1;
    edge_sel_e  sel0;
    logic [1:0] run;
  } ctrl_t;

  localparam logic [ADDR_W-1:0] ADR_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_FLAG = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_CAP0 = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_CAP1 = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_CNT  = 3'd4;
endpackage

// File: rtl/dec_counter.sv
module dec_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)        cnt_q <= '0;
    else if (run_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = run_i && (cnt_q == CNT_MAX);

  // R2: stopped counter keeps its value
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> $stable(cnt_q));
  // R2: running counter advances by one
  a_r2_step: assert property (@(posedge clk) disable iff (rst)
    (run_i && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/dec_filter.sv
module dec_filter
  import dec_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      pin_i,
  input  logic      smp_en_i,
  input  edge_sel_e sel_i,
  output logic      fire_o
);
  logic h0_q, h1_q, flt_q;
  logic qual, want;

  // two-deep sample history and the accepted level
  always_ff @(posedge clk) begin
    if (rst) begin
      h0_q  <= 1'b0;
      h1_q  <= 1'b0;
      flt_q <= 1'b0;
    end else begin
      if (smp_en_i) begin
        h0_q <= pin_i;
        h1_q <= h0_q;
      end
      if (qual) flt_q <= h0_q;
    end
  end

  assign qual = (h0_q == h1_q) && (h0_q != flt_q);

  always_comb begin
    unique case (sel_i)
      EDGE_FALL: want = !h0_q;
      EDGE_RISE: want = h0_q;
      EDGE_OFF:  want = 1'b0;
      default:   want = 1'b1;
    endcase
  end

  assign fire_o = qual && want;

  // R4: accepted level moves only to a level seen on both stored samples
  a_r4_confirm: assert property (@(posedge clk) disable iff (rst)
    !$stable(flt_q) |-> ($past(h0_q) == flt_q && $past(h1_q) == flt_q));
  // R7: without a sampling enable the history does not move
  a_r7_no_sample: assert property (@(posedge clk) disable iff (rst)
    !smp_en_i |=> ($stable(h0_q) && $stable(h1_q)));
endmodule

// File: rtl/dual_edge_capture.sv
module dual_edge_capture
  import dec_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sample_tick,
  input  logic [NCH-1:0]    trig,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  output logic [NCH-1:0]    cap_evt
);
  localparam int CTRL_W = $bits(ctrl_t);
  localparam int FLAG_W = NCH + 1;

  ctrl_t             ctrl_q;
  logic [FLAG_W-1:0] flag_q;
  logic [FLAG_W-1:0] clr;
  logic [CNT_W-1:0]  cnt;
  logic              wrap;
  logic [NCH-1:0]    fire;
  logic [NCH-1:0]    evt_q;
  logic [CNT_W-1:0]  cap_q [NCH];
  edge_sel_e         sel_v [NCH];

  dec_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .run_i  (|ctrl_q.run),
    .cnt_o  (cnt),
    .wrap_o (wrap)
  );

  assign sel_v[0] = ctrl_q.sel0;
  assign sel_v[1] = ctrl_q.sel1;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    dec_filter u_flt (
      .clk      (clk),
      .rst      (rst),
      .pin_i    (trig[g]),
      .smp_en_i (ctrl_q.src[g] | sample_tick),
      .sel_i    (sel_v[g]),
      .fire_o   (fire[g])
    );
  end

  assign clr = (wr_en && wr_addr == ADR_FLAG) ? wr_data[FLAG_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      flag_q <= '0;
      evt_q  <= '0;
      for (int i = 0; i < NCH; i++) cap_q[i] <= '0;
    end else begin
      if (wr_en && wr_addr == ADR_CTRL) ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
      flag_q <= (flag_q & ~clr) | {wrap, fire};
      evt_q  <= fire;
      for (int i = 0; i < NCH; i++)
        if (fire[i]) cap_q[i] <= cnt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      case (rd_addr)
        ADR_CTRL: rd_data <= {{(CNT_W-CTRL_W){1'b0}}, ctrl_q};
        ADR_FLAG: rd_data <= {{(CNT_W-FLAG_W){1'b0}}, flag_q};
        ADR_CAP0: rd_data <= cap_q[0];
        ADR_CAP1: rd_data <= cap_q[1];
        ADR_CNT:  rd_data <= cnt;
        default:  rd_data <= '0;
      endcase
    end
  end

  assign cap_evt = evt_q;

  // R3: a wrap step leaves the wrap flag set
  a_r3_wrap_flag: assert property (@(posedge clk) disable iff (rst)
    wrap |=> flag_q[NCH]);
  // R8: event pulses last one cycle
  a_r8_evt_single0: assert property (@(posedge clk) disable iff (rst)
    evt_q[0] |=> !evt_q[0]);
  a_r8_evt_single1: assert property (@(posedge clk) disable iff (rst)
    evt_q[1] |=> !evt_q[1]);
  // R8: an event is always accompanied by its flag
  a_r8_flag_set: assert property (@(posedge clk) disable iff (rst)
    evt_q[0] |-> flag_q[0]);
  // R9: simultaneous captures hold equal values
  a_r9_same: assert property (@(posedge clk) disable iff (rst)
    (evt_q[0] && evt_q[1]) |-> (cap_q[0] == cap_q[1]));
endmodule

// File: tb/test_dual_edge_capture.sv
module test_dual_edge_capture;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sample_tick = 1'b0;
  logic [1:0]  trig = 2'b00;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic [1:0]  cap_evt;

  int total = 0;
  int bad = 0;
  int ev0 = 0;
  int ev1 = 0;
  logic [1:0] ph = '0;

  always #4 clk = ~clk;

  dual_edge_capture i_dual_edge_capture (
    .clk(clk), .rst(rst), .sample_tick(sample_tick), .trig(trig),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .cap_evt(cap_evt)
  );

  // tick high one clock in four, changed away from the rising edge
  always @(negedge clk) begin
    ph <= ph + 2'd1;
    sample_tick <= (ph == 2'd3);
    if (cap_evt[0]) ev0++;
    if (cap_evt[1]) ev1++;
  end

  // fields: [9:8] polarity ch0, [7] source, [6] idle level, [5:2] hold, [1:0] expected events
  localparam logic [9:0] VEC [10] = '{
    {2'd1, 1'b1, 1'b0, 4'd3, 2'd1},
    {2'd0, 1'b1, 1'b0, 4'd3, 2'd1},
    {2'd2, 1'b1, 1'b0, 4'd3, 2'd0},
    {2'd3, 1'b1, 1'b0, 4'd3, 2'd2},
    {2'd3, 1'b1, 1'b0, 4'd1, 2'd0},
    {2'd3, 1'b1, 1'b1, 4'd2, 2'd2},
    {2'd1, 1'b0, 1'b0, 4'd2, 2'd1},
    {2'd3, 1'b0, 1'b0, 4'd1, 2'd0},
    {2'd0, 1'b0, 1'b1, 4'd2, 2'd1},
    {2'd3, 1'b0, 1'b1, 4'd3, 2'd2}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a[2:0]; wr_data = d[15:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk);
    rd_addr = a[2:0];
    @(posedge clk);
    @(negedge clk);
    v = int'(rd_data);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int v, a, b, base, hold, ctrl;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    for (int r = 0; r < 5; r++) begin
      rd(r, v);
      chk(v == 0, $sformatf("R1 reg %0d", r), v, 0);
    end
    chk(cap_evt == 2'b00, "R1 events", int'(cap_evt), 0);

    // R10 unused address
    rd(6, v);
    chk(v == 0, "R10 unused address", v, 0);

    // R2 running and stopped
    wr(0, 1);
    rd(0, v);
    chk(v == 1, "R10 control readback", v, 1);
    rd(4, a);
    repeat (10) @(posedge clk);
    rd(4, b);
    chk(b - a == 11, "R2 running step", b - a, 11);
    wr(0, 0);
    rd(4, a);
    repeat (10) @(posedge clk);
    rd(4, b);
    chk(a == b, "R2 stopped hold", b, a);

    // R4 R6 R7 table walk on channel 0
    for (int i = 0; i < 10; i++) begin
      ctrl = (int'(VEC[i][7]) << 6) | (2 << 4) | (int'(VEC[i][9:8]) << 2) | 1;
      wr(0, ctrl);
      trig[0] = VEC[i][6];
      repeat (12) @(negedge clk);
      base = ev0;
      hold = VEC[i][7] ? int'(VEC[i][5:2]) : 4 * int'(VEC[i][5:2]);
      trig[0] = ~VEC[i][6];
      repeat (hold) @(negedge clk);
      trig[0] = VEC[i][6];
      repeat (16) @(negedge clk);
      chk(ev0 - base == int'(VEC[i][1:0]),
          $sformatf("R4/R6/R7 vector %0d", i), ev0 - base, int'(VEC[i][1:0]));
    end

    // R5 latency with per-clock sampling, rising on both channels
    wr(0, 'hD5);
    trig = 2'b00;
    repeat (8) @(negedge clk);
    trig[0] = 1'b1;
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      chk(cap_evt[0] == (k == 3), $sformatf("R5 latency clock %0d", k),
          int'(cap_evt[0]), int'(k == 3));
    end

    // R9 simultaneous qualification
    trig = 2'b00;
    repeat (8) @(negedge clk);
    wr(1, 7);
    trig = 2'b11;
    repeat (6) @(negedge clk);
    rd(2, a);
    rd(3, b);
    chk(a == b, "R9 equal captures", b, a);
    rd(1, v);
    chk((v & 3) == 3, "R8 both flags set", v & 3, 3);

    // R5 spacing of five clocks
    trig = 2'b00;
    repeat (8) @(negedge clk);
    trig[0] = 1'b1;
    repeat (5) @(negedge clk);
    trig[1] = 1'b1;
    repeat (8) @(negedge clk);
    rd(2, a);
    rd(3, b);
    chk(b - a == 5, "R5 capture spacing", b - a, 5);

    // R8 write-one-to-clear
    wr(1, 0);
    rd(1, v);
    chk((v & 3) == 3, "R8 write 0 keeps flags", v & 3, 3);
    wr(1, 1);
    rd(1, v);
    chk((v & 3) == 2, "R8 write 1 clears bit", v & 3, 2);

    // R3 wrap flag
    wr(1, 7);
    rd(1, v);
    chk((v & 4) == 0, "R3 wrap clear before", v & 4, 0);
    repeat (65540) @(posedge clk);
    rd(1, v);
    chk((v & 4) == 4, "R3 wrap flag set", v & 4, 4);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule